// File: doc/BRIEF.md
# Compare-and-Skip Instruction Unit

This block executes two compare-and-skip instructions of a small 8-bit accumulator-style core. It takes the instruction word now in execute and works out a 12-bit data-memory address from the word. That address uses either a fixed access window or a 4-bit bank register. The block reads that location through a register-file read port and compares the byte, unsigned, against the working register W. When the condition holds, the block cancels the following instruction, which the fetch unit has already fetched, and inserts no-op cycles in its place. It inserts one more no-op cycle when the cancelled word opens a two-word instruction.

Each accepted word moves through an accept cycle, which decodes the word and registers the address, and then a resolve cycle. In the resolve cycle the byte is compared and the registered results appear with a one-cycle `done` pulse. The block then holds `busy` high through any flush cycles, and the fetch unit waits on it. The block reports whether the skip was taken, the total cycle count and the program counter of the next instruction that will really execute. It never writes W, the file register or any status flag.

Top module: `skip_unit`

## Requirements
- R1: A word whose bits [15:9] are 0110010 is skip-if-greater, and one whose bits [15:9] are 0110000 is skip-if-less. Any other word completes with skip_taken=0 and cycle_count=1.
- R2: With bit 8 (a) clear, rf_addr is {4'h0,f} for f below 0x80 and {4'hF,f} for f of 0x80 or more, where f is bits [7:0]. The bank register is ignored.
- R3: With bit 8 set, rf_addr is {bank,f}.
- R4: Skip-if-greater skips exactly when the file byte is greater than W, compared unsigned.
- R5: Skip-if-less skips exactly when the file byte is less than W, compared unsigned. Equal values never skip, for either instruction.
- R6: cycle_count is 1 with no skip, 2 for a skip and 3 for a skip whose cancelled word has top nibble 0xC, 0xE or 0xF. extra_flush is high only in that last case.
- R7: After the done pulse, busy stays high for exactly cycle_count-1 cycles. An ex_valid seen while busy is high is ignored.
- R8: pc_next equals the accepted pc_in plus 2*cycle_count, modulo 2^16.
- R9: Synchronous reset clears busy, done, skip_taken, extra_flush, cycle_count and rf_addr, and it cancels any pending flush. The first instruction after reset is accepted and is never discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Instruction word offered for execution |
| ex_word | input | 16 | Instruction word in execute |
| nxt_opc | input | 4 | Top nibble of the already-fetched next word |
| bank_sel | input | 4 | Bank register |
| wreg | input | 8 | Working register W |
| pc_in | input | 16 | Byte address of the instruction in execute |
| rf_addr | output | 12 | Register-file read address |
| rf_rdata | input | 8 | Register-file read data for rf_addr, valid in the same cycle |
| busy | output | 1 | Fetch hold: resolve or flush cycle in progress |
| done | output | 1 | One-cycle pulse when results update |
| skip_taken | output | 1 | Following instruction was cancelled |
| extra_flush | output | 1 | Cancelled word was a two-word opener |
| cycle_count | output | 2 | Cycles used by the instruction, 1 to 3 |
| pc_next | output | 16 | Byte address of the next instruction that executes |

## Verification
The assertions assume that rf_rdata returns the byte at rf_addr without delay, and that ex_valid is only meaningful while busy is low. They also assume nxt_opc holds the real next word when an instruction is accepted. The bench models the register file as a combinational array indexed by rf_addr. It drives new words only after it has seen busy fall, except in the one test that deliberately offers a word during a flush to confirm that the word is dropped.

// File: rtl/skip_pkg.sv
package skip_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_GT = 2'd1, OP_LT = 2'd2} cmp_op_e;
endpackage

// File: rtl/skip_decode.sv
module skip_decode import skip_pkg::*; #(
  parameter int IW   = 16,
  parameter int DW   = 8,
  parameter int BSRW = 4,
  localparam int AW  = BSRW + DW,
  localparam int OPW = IW - DW - 1
) (
  input  logic [IW-1:0]   word,
  input  logic [BSRW-1:0] bank_sel,
  output cmp_op_e         op,
  output logic [AW-1:0]   addr
);
  localparam logic [OPW-1:0] OPC_GT = OPW'(7'b0110010);
  localparam logic [OPW-1:0] OPC_LT = OPW'(7'b0110000);

  logic [DW-1:0]   fld;
  logic            use_bank;
  logic [BSRW-1:0] hi;

  assign fld      = word[DW-1:0];
  assign use_bank = word[DW];

  always_comb begin
    if (word[IW-1:DW+1] == OPC_GT)      op = OP_GT;
    else if (word[IW-1:DW+1] == OPC_LT) op = OP_LT;
    else                                op = OP_NONE;
  end

  // Access window: lower half in bank 0, upper half in the top bank.
  always_comb begin
    if (use_bank)      hi = bank_sel;
    else if (fld[DW-1]) hi = '1;
    else               hi = '0;
  end

  assign addr = {hi, fld};
endmodule

// File: rtl/skip_compare.sv
module skip_compare import skip_pkg::*; #(
  parameter int DW = 8
) (
  input  cmp_op_e       op,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] wval,
  output logic          cond
);
  logic [DW:0] diff;
  logic        below;
  logic        same;

  // Unsigned subtraction: borrow means operand below W.
  assign diff  = {1'b0, opnd} - {1'b0, wval};
  assign below = diff[DW];
  assign same  = (diff[DW-1:0] == '0);

  always_comb begin
    unique case (op)
      OP_GT:   cond = !below && !same;
      OP_LT:   cond = below;
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/skip_flush.sv
module skip_flush #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  output logic          active
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)               remain <= '0;
    else if (load)         remain <= load_cnt;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/skip_unit.sv
module skip_unit import skip_pkg::*; #(
  parameter int IW   = 16,
  parameter int DW   = 8,
  parameter int BSRW = 4,
  parameter int PCW  = 16,
  parameter int CW   = 2,
  localparam int AW  = BSRW + DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ex_valid,
  input  logic [IW-1:0]   ex_word,
  input  logic [3:0]      nxt_opc,
  input  logic [BSRW-1:0] bank_sel,
  input  logic [DW-1:0]   wreg,
  input  logic [PCW-1:0]  pc_in,
  output logic [AW-1:0]   rf_addr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            busy,
  output logic            done,
  output logic            skip_taken,
  output logic            extra_flush,
  output logic [CW-1:0]   cycle_count,
  output logic [PCW-1:0]  pc_next
);
  cmp_op_e        dec_op, op_q;
  logic [AW-1:0]  dec_addr;
  logic           pend;
  logic [DW-1:0]  w_q;
  logic           two_q;
  logic [PCW-1:0] pc_q;
  logic           cond;
  logic           flushing;
  logic           accept;
  logic           two_word;
  logic [CW-1:0]  cnt_d;
  logic [CW-1:0]  flush_len;

  skip_decode #(.IW(IW), .DW(DW), .BSRW(BSRW)) u_dec (
    .word(ex_word), .bank_sel(bank_sel), .op(dec_op), .addr(dec_addr)
  );

  skip_compare #(.DW(DW)) u_cmp (
    .op(op_q), .opnd(rf_rdata), .wval(w_q), .cond(cond)
  );

  assign two_word  = (nxt_opc == 4'hC) || (nxt_opc == 4'hE) || (nxt_opc == 4'hF);
  assign flush_len = two_q ? CW'(2) : CW'(1);
  assign cnt_d     = cond ? (flush_len + CW'(1)) : CW'(1);

  skip_flush #(.CW(CW)) u_flush (
    .clk(clk), .rst(rst), .load(pend && cond), .load_cnt(flush_len), .active(flushing)
  );

  assign busy   = pend | flushing;
  assign accept = ex_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= 1'b0;
      op_q        <= OP_NONE;
      w_q         <= '0;
      two_q       <= 1'b0;
      pc_q        <= '0;
      rf_addr     <= '0;
      done        <= 1'b0;
      skip_taken  <= 1'b0;
      extra_flush <= 1'b0;
      cycle_count <= '0;
      pc_next     <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        pend    <= 1'b1;
        op_q    <= dec_op;
        w_q     <= wreg;
        two_q   <= two_word;
        pc_q    <= pc_in;
        rf_addr <= dec_addr;
      end
      if (pend) begin
        pend        <= 1'b0;
        done        <= 1'b1;
        skip_taken  <= cond;
        extra_flush <= cond && two_q;
        cycle_count <= cnt_d;
        pc_next     <= pc_q + PCW'({cnt_d, 1'b0});
      end
    end
  end
endmodule

// File: rtl/skip_unit_chk.sv
module skip_unit_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          skip_taken,
  input logic          extra_flush,
  input logic [CW-1:0] cycle_count
);
  // R6
  extra_needs_skip_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!extra_flush || skip_taken));

  // R6
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycle_count == CW'(1) + CW'(skip_taken) + CW'(extra_flush)));

  // R7
  skip_holds_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (done && skip_taken) |-> busy);

  // R7
  no_skip_releases_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !skip_taken) |-> !busy);

  // R7
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind skip_unit skip_unit_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .skip_taken(skip_taken), .extra_flush(extra_flush), .cycle_count(cycle_count)
);

// File: tb/skip_unit_bench.sv
module skip_unit_bench;
  localparam int PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        ex_valid;
  logic [15:0] ex_word;
  logic [3:0]  nxt_opc;
  logic [3:0]  bank_sel;
  logic [7:0]  wreg;
  logic [15:0] pc_in;
  logic [11:0] rf_addr;
  logic [7:0]  rf_rdata;
  logic        busy, done, skip_taken, extra_flush;
  logic [1:0]  cycle_count;
  logic [15:0] pc_next;
  logic [7:0]  mem [0:4095];

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;
  assign rf_rdata = mem[rf_addr];

  skip_unit u_skip_unit (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_word(ex_word), .nxt_opc(nxt_opc),
    .bank_sel(bank_sel), .wreg(wreg), .pc_in(pc_in), .rf_addr(rf_addr),
    .rf_rdata(rf_rdata), .busy(busy), .done(done), .skip_taken(skip_taken),
    .extra_flush(extra_flush), .cycle_count(cycle_count), .pc_next(pc_next)
  );

  // {word, next nibble, bank, W, file byte, exp skip, exp count, exp addr}
  localparam logic [54:0] VEC [NV] = '{
    {16'h6420, 4'h0, 4'h3, 8'h10, 8'h30, 1'b1, 2'd2, 12'h020}, // R4 greater
    {16'h6420, 4'h0, 4'h3, 8'h30, 8'h30, 1'b0, 2'd1, 12'h020}, // R5 equal GT
    {16'h6420, 4'h0, 4'h3, 8'h80, 8'h05, 1'b0, 2'd1, 12'h020}, // R4 less
    {16'h6420, 4'hC, 4'h3, 8'h7F, 8'hFF, 1'b1, 2'd3, 12'h020}, // R4 unsigned, R6
    {16'h6145, 4'hE, 4'h5, 8'h90, 8'h10, 1'b1, 2'd3, 12'h545}, // R3 R5 R6
    {16'h6045, 4'h0, 4'h5, 8'h44, 8'h44, 1'b0, 2'd1, 12'h045}, // R2 R5 equal
    {16'h609A, 4'h0, 4'h5, 8'h01, 8'h80, 1'b0, 2'd1, 12'hF9A}, // R2 upper, R5
    {16'h609A, 4'hF, 4'h5, 8'h80, 8'h01, 1'b1, 2'd3, 12'hF9A}, // R5 R6
    {16'h6581, 4'hD, 4'hF, 8'h01, 8'h02, 1'b1, 2'd2, 12'hF81}, // R3 R6 not two-word
    {16'h6220, 4'hC, 4'h3, 8'h00, 8'hFF, 1'b0, 2'd1, 12'h020}, // R1 other word
    {16'h6420, 4'hB, 4'h3, 8'h00, 8'h01, 1'b1, 2'd2, 12'h020}, // R6 nibble B
    {16'h6180, 4'h1, 4'h0, 8'h01, 8'h00, 1'b1, 2'd2, 12'h080}  // R3 bank 0
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one word, check resolve outputs, then count flush cycles.
  task automatic run(input logic [15:0] w, input logic [3:0] nx, input logic [3:0] bk,
                     input logic [7:0] wv, input logic [7:0] fb, input logic [11:0] ea,
                     input logic [15:0] pc, input logic es, input logic [1:0] ec);
    int n;
    mem[ea] = fb;
    mem[ea ^ 12'h800] = ~fb;
    @(negedge clk);
    ex_valid = 1'b1; ex_word = w; nxt_opc = nx; bank_sel = bk; wreg = wv; pc_in = pc;
    @(negedge clk);
    ex_valid = 1'b0;
    chk(rf_addr == ea, "R2/R3 address", 32'(rf_addr), 32'(ea));
    @(negedge clk);
    chk(done == 1'b1, "R1 done pulse", 32'(done), 1);
    chk(skip_taken == es, "R4/R5 skip", 32'(skip_taken), 32'(es));
    chk(cycle_count == ec, "R6 count", 32'(cycle_count), 32'(ec));
    chk(extra_flush == (ec == 2'd3), "R6 extra flush", 32'(extra_flush), 32'(ec == 2'd3));
    chk(pc_next == pc + 16'({ec, 1'b0}), "R8 pc", 32'(pc_next), 32'(pc + 16'({ec, 1'b0})));
    n = 0;
    while (busy && n < 6) begin
      n++;
      @(negedge clk);
    end
    chk(n == int'(ec) - 1, "R7 busy length", n, int'(ec) - 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rst = 1'b1; ex_valid = 1'b0; ex_word = '0; nxt_opc = '0;
    bank_sel = '0; wreg = '0; pc_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !skip_taken && !extra_flush, "R9 reset flags",
        {busy, done, skip_taken, extra_flush}, 0);
    chk(cycle_count == 2'd0 && rf_addr == 12'h0, "R9 reset values", {cycle_count, rf_addr}, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      run(VEC[v][54:39], VEC[v][38:35], VEC[v][34:31], VEC[v][30:23], VEC[v][22:15],
          VEC[v][11:0], 16'h0100 + 16'(v * 8), VEC[v][14], VEC[v][13:12]);

    // R8 wrap of the program counter
    run(16'h6420, 4'hE, 4'h0, 8'h00, 8'h09, 12'h020, 16'hFFFC, 1'b1, 2'd3);

    // R7 a word offered during a flush is dropped
    mem[12'h020] = 8'h50;
    @(negedge clk);
    ex_valid = 1'b1; ex_word = 16'h6420; nxt_opc = 4'hF; wreg = 8'h10; pc_in = 16'h0200;
    @(negedge clk);
    ex_word = 16'h6133; bank_sel = 4'h7; nxt_opc = 4'h0;
    @(negedge clk);
    chk(done && skip_taken, "R7 skip before drop", {done, skip_taken}, 3);
    @(negedge clk);
    @(negedge clk);
    ex_valid = 1'b0;
    chk(!done && rf_addr == 12'h020, "R7 ignored during busy", {done, rf_addr}, 12'h020);
    @(negedge clk);
    chk(!done && !busy, "R7 no late completion", {done, busy}, 0);

    // R9 reset during a flush, then first instruction is not discarded
    mem[12'h030] = 8'h90;
    @(negedge clk);
    ex_valid = 1'b1; ex_word = 16'h6430; nxt_opc = 4'hC; wreg = 8'h10; pc_in = 16'h0300;
    @(negedge clk);
    ex_valid = 1'b0;
    @(negedge clk);
    chk(busy && skip_taken, "R9 flush running", {busy, skip_taken}, 3);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !skip_taken, "R9 flush cancelled", {busy, skip_taken}, 0);
    mem[12'h031] = 8'h01;
    ex_valid = 1'b1; ex_word = 16'h6431; nxt_opc = 4'h0; wreg = 8'h05; pc_in = 16'h0400;
    @(negedge clk);
    ex_valid = 1'b0;
    chk(busy && rf_addr == 12'h031, "R9 first accepted", {busy, rf_addr}, {1'b1, 12'h031});
    @(negedge clk);
    chk(done && cycle_count == 2'd1 && pc_next == 16'h0402, "R9 first completes",
        {done, cycle_count, pc_next}, {1'b1, 2'd1, 16'h0402});

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule